// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of an in-order five-stage integer pipeline, where the execute stage should take its value from. The three choices are the register-file value captured when the instruction left decode, the result sitting in the execute/memory pipeline register, or the result sitting in the memory/writeback pipeline register. Each source register number travels with its instruction, so the execute stage can compare it against the destination numbers of the two older instructions ahead of it.

A hit on a stage counts only when that older instruction actually writes a register and its destination is not register 0, which always reads as zero. When both older stages hit the same source, the execute/memory stage is chosen because it carries the younger write. The two operands are resolved independently of each other. The selection logic is purely combinational. A thin wrapper around it registers the two selects and the two muxed operands on the rising clock edge so that the result can be observed and checked at a clock boundary.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory stage has write enable high, a nonzero destination, and that destination equals an operand's source number, that operand's select is 2'b10 and its operand output equals the execute/memory result.
- R2: When only the memory/writeback stage qualifies for an operand (write enable high, nonzero destination equal to the source), the select is 2'b01 and the operand output equals the writeback result.
- R3: A stage whose write enable is low never causes forwarding, whatever its destination number.
- R4: A destination number of 0 never causes forwarding. An operand whose source is register 0 always gets select 2'b00.
- R5: When both stages qualify for the same operand, the select is 2'b10 (execute/memory wins).
- R6: With no qualifying stage the select is 2'b00 and the operand output equals that operand's register-file value.
- R7: Operands A and B are resolved independently. Both may forward in the same cycle, from the same stage or from different stages. The select value 2'b11 never appears.
- R8: Selects and operands appear at the outputs on the rising clock edge after the inputs are applied. An active-low asynchronous reset clears all four outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 5 | Source register number of operand A in execute |
| src_b | input | 5 | Source register number of operand B in execute |
| exm_rd | input | 5 | Destination register of the execute/memory instruction |
| exm_we | input | 1 | Register-write enable of the execute/memory instruction |
| wb_rd | input | 5 | Destination register of the memory/writeback instruction |
| wb_we | input | 1 | Register-write enable of the memory/writeback instruction |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| exm_data | input | 32 | Result held in the execute/memory register |
| wb_data | input | 32 | Result held in the memory/writeback register |
| sel_a | output | 2 | Registered select for operand A (00 file, 10 exe/mem, 01 writeback) |
| sel_b | output | 2 | Registered select for operand B |
| opnd_a | output | 32 | Registered muxed operand A |
| opnd_b | output | 32 | Registered muxed operand B |

## Verification
The hardest case to reach is a double hit: both older stages write the same nonzero register that the execute stage reads. In a real program this means two back-to-back writes to one register followed by a read. Combined with a write-enable or zero-register disqualification on the stage that would otherwise win, it only shows up in rare instruction mixes. The stimulus table builds these situations directly. It places the same destination in both stages, then turns off the enable on the younger stage or uses register 0 as the destination, and also models a write followed by three dependent reads as the result moves from one stage to the next.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int N_OPND = 2;
    localparam logic [1:0] SEL_RF  = 2'b00;
    localparam logic [1:0] SEL_WB  = 2'b01;
    localparam logic [1:0] SEL_EXM = 2'b10;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             exm_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output logic [1:0]       sel
);
    import fwd_pkg::*;

    logic exm_hit;
    logic wb_hit;

    always_comb begin
        exm_hit = exm_we && (exm_rd != '0) && (exm_rd == src);
        wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        if (exm_hit)     sel = SEL_EXM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end
endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] dout
);
    import fwd_pkg::*;

    always_comb begin
        case (sel)
            SEL_EXM: dout = exm_val;
            SEL_WB:  dout = wb_val;
            default: dout = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic [REG_W-1:0]  exm_rd,
    input  logic              exm_we,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic              wb_we,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic [DATA_W-1:0] exm_data,
    input  logic [DATA_W-1:0] wb_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    import fwd_pkg::*;

    typedef struct packed {
        logic [1:0]        sel_a;
        logic [1:0]        sel_b;
        logic [DATA_W-1:0] opnd_a;
        logic [DATA_W-1:0] opnd_b;
    } out_t;

    logic [REG_W-1:0]  src_arr [N_OPND];
    logic [DATA_W-1:0] rf_arr  [N_OPND];
    logic [1:0]        sel_arr [N_OPND];
    logic [DATA_W-1:0] val_arr [N_OPND];

    out_t out_d, out_q;

    assign src_arr[0] = src_a;
    assign src_arr[1] = src_b;
    assign rf_arr[0]  = rf_a;
    assign rf_arr[1]  = rf_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fwd_src_match #(.REG_W(REG_W)) u_match (
            .src    (src_arr[g]),
            .exm_rd (exm_rd),
            .exm_we (exm_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel_arr[g])
        );
        fwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_arr[g]),
            .rf_val  (rf_arr[g]),
            .exm_val (exm_data),
            .wb_val  (wb_data),
            .dout    (val_arr[g])
        );
    end

    always_comb begin
        out_d        = out_q;
        out_d.sel_a  = sel_arr[0];
        out_d.sel_b  = sel_arr[1];
        out_d.opnd_a = val_arr[0];
        out_d.opnd_b = val_arr[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sel_a  = out_q.sel_a;
    assign sel_b  = out_q.sel_b;
    assign opnd_a = out_q.opnd_a;
    assign opnd_b = out_q.opnd_b;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  src_a,
    input logic [REG_W-1:0]  src_b,
    input logic [REG_W-1:0]  exm_rd,
    input logic              exm_we,
    input logic [REG_W-1:0]  wb_rd,
    input logic              wb_we,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic [DATA_W-1:0] exm_data,
    input logic [DATA_W-1:0] wb_data,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_EXM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(exm_we && (exm_rd != '0) && (exm_rd == src_a)) |-> sel_a == 2'b10); // R5
    AST_WB_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(wb_we && (wb_rd != '0) && (wb_rd == src_b) && !(exm_we && (exm_rd == src_b)))
        |-> sel_b == 2'b01); // R2
    AST_NO_WRITE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(!exm_we && !wb_we) |-> (sel_a == 2'b00) && (sel_b == 2'b00)); // R3
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(src_a == '0) |-> sel_a == 2'b00); // R4
    AST_EXM_DATA_A: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (sel_a == 2'b10) |-> opnd_a == $past(exm_data)); // R1
    AST_WB_DATA_A: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (sel_a == 2'b01) |-> opnd_a == $past(wb_data)); // R2
    AST_RF_DATA_A: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (sel_a == 2'b00) |-> opnd_a == $past(rf_a)); // R6
    AST_RF_DATA_B: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && (sel_b == 2'b00) |-> opnd_b == $past(rf_b)); // R6
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11)); // R7
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .exm_rd(exm_rd), .exm_we(exm_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .rf_a(rf_a), .rf_b(rf_b), .exm_data(exm_data), .wb_data(wb_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
);

// File: tb/fwd_unit_tb.sv
`timescale 1ns/1ps
module fwd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_a = '0, src_b = '0, exm_rd = '0, wb_rd = '0;
    logic        exm_we = 1'b0, wb_we = 1'b0;
    logic [31:0] rf_a = '0, rf_b = '0, exm_data = '0, wb_data = '0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .exm_rd(exm_rd), .exm_we(exm_we), .wb_rd(wb_rd), .wb_we(wb_we),
        .rf_a(rf_a), .rf_b(rf_b), .exm_data(exm_data), .wb_data(wb_data),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // fields: src_a, src_b, exm_rd, exm_we, wb_rd, wb_we, exp sel_a, exp sel_b, requirement
    localparam int NV = 15;
    localparam logic [29:0] VEC [NV] = '{
        {5'd1,  5'd3,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 4'd6},
        {5'd2,  5'd5,  5'd2,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00, 4'd1},
        {5'd6,  5'd2,  5'd7,  1'b1, 5'd2,  1'b1, 2'b00, 2'b01, 4'd2},
        {5'd2,  5'd2,  5'd9,  1'b1, 5'd2,  1'b1, 2'b01, 2'b01, 4'd7},
        {5'd2,  5'd2,  5'd2,  1'b1, 5'd2,  1'b1, 2'b10, 2'b10, 4'd5},
        {5'd4,  5'd8,  5'd4,  1'b0, 5'd8,  1'b0, 2'b00, 2'b00, 4'd3},
        {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 4'd4},
        {5'd0,  5'd3,  5'd0,  1'b1, 5'd3,  1'b1, 2'b00, 2'b01, 4'd4},
        {5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 2'b10, 2'b01, 4'd7},
        {5'd31, 5'd31, 5'd31, 1'b0, 5'd31, 1'b1, 2'b01, 2'b01, 4'd3},
        {5'd12, 5'd13, 5'd13, 1'b1, 5'd12, 1'b0, 2'b00, 2'b10, 4'd3},
        {5'd5,  5'd6,  5'd6,  1'b1, 5'd5,  1'b1, 2'b01, 2'b10, 4'd7},
        // write to r2, then three dependent reads as the result moves down
        {5'd2,  5'd5,  5'd2,  1'b1, 5'd17, 1'b1, 2'b10, 2'b00, 4'd1},
        {5'd6,  5'd2,  5'd20, 1'b1, 5'd2,  1'b1, 2'b00, 2'b01, 4'd2},
        {5'd2,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 4'd6}
    };

    function automatic string rname(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf,
                                         input logic [31:0] ex, input logic [31:0] wb);
        if (s == 2'b10)      return ex;
        else if (s == 2'b01) return wb;
        else                 return rf;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_data(input int k);
        rf_a     = 32'hA000_0000 + k;
        rf_b     = 32'hB000_0000 + k;
        exm_data = 32'hE000_0000 + k;
        wb_data  = 32'hD000_0000 + k;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] ea, eb;
        logic [31:0] xa, xb;
        set_data(99);
        src_a = 5'd2; exm_rd = 5'd2; exm_we = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset clears outputs even with a hazard present at the inputs
        chk("R8", "reset sel_a", {30'd0, sel_a}, 32'd0);
        chk("R8", "reset opnd_a", opnd_a, 32'd0);
        chk("R8", "reset opnd_b", opnd_b, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {src_a, src_b, exm_rd, exm_we, wb_rd, wb_we} = VEC[i][29:8];
            set_data(i);
            ea = VEC[i][7:6];
            eb = VEC[i][5:4];
            xa = pick(ea, rf_a, exm_data, wb_data);
            xb = pick(eb, rf_b, exm_data, wb_data);
            @(negedge clk);
            chk(rname(int'(VEC[i][3:0])), $sformatf("vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, ea});
            chk(rname(int'(VEC[i][3:0])), $sformatf("vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, eb});
            chk(rname(int'(VEC[i][3:0])), $sformatf("vec%0d opnd_a", i), opnd_a, xa);
            chk(rname(int'(VEC[i][3:0])), $sformatf("vec%0d opnd_b", i), opnd_b, xb);
        end

        // R8: outputs hold until the next rising edge after an input change
        @(negedge clk);
        src_a = 5'd9; exm_rd = 5'd9; exm_we = 1'b1; wb_we = 1'b0;
        set_data(200);
        #2;
        chk("R8", "hold before edge sel_a", {30'd0, sel_a}, 32'd0);
        @(negedge clk);
        chk("R8", "update after edge sel_a", {30'd0, sel_a}, 32'd2);
        chk("R1", "exm operand value", opnd_a, 32'hE000_00C8);

        // R8: asynchronous reset mid-run
        #3 rst_n = 1'b0;
        #2;
        chk("R8", "async reset sel_a", {30'd0, sel_a}, 32'd0);
        chk("R8", "async reset opnd_a", opnd_a, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "forward after reset release", {30'd0, sel_a}, 32'd2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule